// File: doc/BRIEF.md
# Time-Base Counter with Keyed Clear

A free-running binary time base that advances by one on every clock and can be forced back to zero only by software. Software does this through a byte-wide, write-only clear register on a simple peripheral bus. It must first write an arming key and then a firing key. Between the two writes any amount of time may pass, and any stray value aborts the sequence. Because a single wild write cannot reset the time base, the intervals derived from it are protected against runaway code.

A set of selected counter bits is registered and brought out as tap levels, together with a one-cycle pulse each time a tap bit goes high. Downstream logic uses these taps as the time reference for an oscillator-settling wait and a watchdog. A keyed clear restarts every tap from zero, so the derived interval that is in progress is stretched. Reads of the clear register have no side effects and return a fixed all-zero pattern.

Top module: `timebase_keyclr`

## Requirements
- R1: A synchronous active-high reset sets the counter, all tap levels and all tap pulses to zero, and leaves the key tracker unarmed: a 0x5A written after reset, with no 0xA5 written first, does not clear the counter.
- R2: Outside a clear, the counter grows by exactly one on every clock and wraps from all ones to zero.
- R3: A write of 0xA5 to the clear address (default 0x483) arms the tracker. A later write of 0x5A to that address while armed makes the counter read zero on the clock edge that accepts the write. On the following edge it reads one.
- R4: The armed state has no time limit. A 0x5A written after any number of idle cycles still clears the counter.
- R5: A write of 0x5A while the tracker is unarmed has no effect on the counter.
- R6: Writes to any other address, and reads at any address, leave the tracker unchanged.
- R7: While armed, a further 0xA5 write keeps the tracker armed. A write of any value other than 0xA5 or 0x5A disarms it, so a following 0x5A does not clear.
- R8: The tracker disarms on the edge at which a clear fires, so a second 0x5A straight after a clear has no effect.
- R9: The read data bus is always 0x00.
- R10: Tap level i equals counter bit TAP_POS[i] one clock later. Tap pulse i is high for exactly the cycle in which tap level i changes from 0 to 1.
- R11: Two edges after a clear is accepted, every tap level is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Peripheral byte address |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, fixed 0x00 |
| count | output | CNT_W | Current time-base value |
| tap_level | output | NUM_TAPS | Registered tap bits |
| tap_rise | output | NUM_TAPS | One-cycle pulse on a tap rising |

## Verification
The bench builds the block with an 8-bit counter and taps on bits 1, 3, 5 and 7. Address width and clear address keep their defaults. With this counter the wrap from 255 to 0 comes within reach in a few hundred cycles, and each tap, including the top one, rises and falls several times inside one observation window. A clear while bit 7 is high therefore shows the taps restarting. The key sequences are walked as a vector table that covers arming, disarming, re-arming, foreign addresses and reads, and the long idle gap between keys is exercised separately.

// File: rtl/tbclr_pkg.sv
package tbclr_pkg;

    localparam int          BYTE_W   = 8;
    localparam logic [7:0]  KEY_ARM  = 8'hA5;
    localparam logic [7:0]  KEY_FIRE = 8'h5A;
    localparam logic [7:0]  RD_FILL  = 8'h00;

    typedef enum logic {
        TRK_IDLE  = 1'b0,
        TRK_ARMED = 1'b1
    } trk_state_e;

    typedef enum logic [1:0] {
        KEY_NONE  = 2'd0,
        KEY_ISARM = 2'd1,
        KEY_ISFIRE = 2'd2,
        KEY_OTHER = 2'd3
    } key_kind_e;

    typedef struct packed {
        logic              hit;
        logic [BYTE_W-1:0] data;
    } key_wr_t;

    function automatic key_kind_e classify(key_wr_t w);
        if (!w.hit)                 return KEY_NONE;
        else if (w.data == KEY_ARM) return KEY_ISARM;
        else if (w.data == KEY_FIRE) return KEY_ISFIRE;
        else                        return KEY_OTHER;
    endfunction

    function automatic trk_state_e next_state(trk_state_e s, key_kind_e k);
        case (k)
            KEY_NONE:  return s;
            KEY_ISARM: return TRK_ARMED;
            default:   return TRK_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/tbclr_key_tracker.sv
module tbclr_key_tracker
    import tbclr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  key_wr_t wr,
    output logic    armed,
    output logic    fire
);

    trk_state_e st_q;
    trk_state_e st_d;
    key_kind_e  kind;

    always_comb begin
        kind = classify(wr);
        st_d = next_state(st_q, kind);
        fire = (st_q == TRK_ARMED) && (kind == KEY_ISFIRE);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= TRK_IDLE;
        else     st_q <= st_d;
    end

    assign armed = (st_q == TRK_ARMED);

endmodule

// File: rtl/tbclr_counter.sv
module tbclr_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else            cnt_q <= cnt_q + ONE;
    end

    assign count = cnt_q;

endmodule

// File: rtl/tbclr_tap_bank.sv
module tbclr_tap_bank #(
    parameter int NUM_TAPS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TAPS-1:0] taps_now,
    output logic [NUM_TAPS-1:0] level,
    output logic [NUM_TAPS-1:0] rise
);

    logic [NUM_TAPS-1:0] level_q;
    logic [NUM_TAPS-1:0] rise_q;

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) begin
                level_q[i] <= 1'b0;
                rise_q[i]  <= 1'b0;
            end else begin
                level_q[i] <= taps_now[i];
                rise_q[i]  <= taps_now[i] & ~level_q[i];
            end
        end
    end

    assign level = level_q;
    assign rise  = rise_q;

endmodule

// File: rtl/timebase_keyclr.sv
module timebase_keyclr
    import tbclr_pkg::*;
#(
    parameter int                      CNT_W    = 20,
    parameter int                      ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]       CLR_ADDR = 12'h483,
    parameter int                      NUM_TAPS = 4,
    parameter logic [NUM_TAPS*8-1:0]   TAP_POS  = {8'd19, 8'd17, 8'd14, 8'd11}
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    output logic [CNT_W-1:0]    count,
    output logic [NUM_TAPS-1:0] tap_level,
    output logic [NUM_TAPS-1:0] tap_rise
);

    logic                addr_hit;
    key_wr_t             key_wr;
    logic                trk_armed;
    logic                clr_fire;
    logic [NUM_TAPS-1:0] taps_now;

    assign addr_hit   = (bus_addr == CLR_ADDR);
    assign key_wr.hit  = bus_wr && addr_hit;
    assign key_wr.data = bus_wdata;

    // Reads are inert; the register returns a fixed pattern.
    assign bus_rdata = (bus_rd && addr_hit) ? RD_FILL : 8'h00;

    tbclr_key_tracker u_trk (
        .clk   (clk),
        .rst   (rst),
        .wr    (key_wr),
        .armed (trk_armed),
        .fire  (clr_fire)
    );

    tbclr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_fire),
        .count (count)
    );

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_sel
        localparam int P = int'(TAP_POS[i*8 +: 8]);
        assign taps_now[i] = count[P];
    end

    tbclr_tap_bank #(.NUM_TAPS(NUM_TAPS)) u_taps (
        .clk      (clk),
        .rst      (rst),
        .taps_now (taps_now),
        .level    (tap_level),
        .rise     (tap_rise)
    );

endmodule

// File: rtl/timebase_keyclr_chk.sv
module timebase_keyclr_chk
    import tbclr_pkg::*;
#(
    parameter int                CNT_W    = 20,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 12'h483,
    parameter int                NUM_TAPS = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [7:0]          bus_wdata,
    input logic [7:0]          bus_rdata,
    input logic [CNT_W-1:0]    count,
    input logic [NUM_TAPS-1:0] tap_level,
    input logic [NUM_TAPS-1:0] tap_rise,
    input logic                armed,
    input logic                fire
);

    logic clr_wr;
    logic exp_fire;
    assign clr_wr   = bus_wr && (bus_addr == CLR_ADDR);
    assign exp_fire = clr_wr && armed && (bus_wdata == KEY_FIRE);

    assert_fire_match_R3: assert property (@(posedge clk) disable iff (rst)
        fire == exp_fire);

    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (rst)
        exp_fire |=> count == '0);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        !exp_fire |=> count == CNT_W'($past(count) + 1'b1));

    assert_unarmed_fire_R5: assert property (@(posedge clk) disable iff (rst)
        (!armed && clr_wr && bus_wdata == KEY_FIRE) |=> !armed);

    assert_foreign_inert_R6: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> armed == $past(armed));

    assert_read_inert_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr) |=> armed == $past(armed));

    assert_rearm_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && bus_wdata == KEY_ARM) |=> armed);

    assert_fire_disarm_R8: assert property (@(posedge clk) disable iff (rst)
        exp_fire |=> !armed);

    assert_rise_level_R10: assert property (@(posedge clk) disable iff (rst)
        (tap_rise & ~tap_level) == '0);

    assert_rise_edge_R10: assert property (@(posedge clk) disable iff (rst)
        (|tap_rise) |=> ((tap_rise & $past(tap_rise)) == '0));

    assert_tap_restart_R11: assert property (@(posedge clk) disable iff (rst)
        exp_fire |=> ##1 tap_level == '0);

    always @(posedge clk) begin
        if (!rst) begin
            assert_rdata_R9: assert (bus_rdata == RD_FILL)
                else $error("read data not fixed");
        end
    end

endmodule

bind timebase_keyclr timebase_keyclr_chk #(
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W),
    .CLR_ADDR (CLR_ADDR),
    .NUM_TAPS (NUM_TAPS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .count     (count),
    .tap_level (tap_level),
    .tap_rise  (tap_rise),
    .armed     (trk_armed),
    .fire      (clr_fire)
);

// File: tb/timebase_keyclr_bench.sv
`timescale 1ns/1ps
module timebase_keyclr_bench;

    localparam int          CW  = 8;
    localparam int          AW  = 12;
    localparam int          NT  = 4;
    localparam logic [11:0] CA  = 12'h483;
    localparam logic [11:0] OA  = 12'h484;
    localparam int          TP [NT] = '{1, 3, 5, 7};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [CW-1:0] count;
    logic [NT-1:0] tap_level;
    logic [NT-1:0] tap_rise;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    timebase_keyclr #(
        .CNT_W(CW), .ADDR_W(AW), .CLR_ADDR(CA), .NUM_TAPS(NT),
        .TAP_POS({8'd7, 8'd5, 8'd3, 8'd1})
    ) u_timebase_keyclr (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .tap_level(tap_level), .tap_rise(tap_rise)
    );

    typedef struct packed {
        logic [11:0] addr;
        logic        wr;
        logic        rd;
        logic [7:0]  data;
        logic        clr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{CA, 1'b1, 1'b0, 8'hA5, 1'b0, 4'd3},  // R3 arm
        '{CA, 1'b1, 1'b0, 8'h5A, 1'b1, 4'd3},  // R3 fire
        '{CA, 1'b1, 1'b0, 8'h5A, 1'b0, 4'd5},  // R5 fire while unarmed
        '{CA, 1'b1, 1'b0, 8'hA5, 1'b0, 4'd6},  // R6 arm
        '{OA, 1'b1, 1'b0, 8'h5A, 1'b0, 4'd6},  // R6 foreign address
        '{OA, 1'b1, 1'b0, 8'h33, 1'b0, 4'd6},  // R6 foreign address, other value
        '{CA, 1'b0, 1'b1, 8'h00, 1'b0, 4'd6},  // R6 read at clear address
        '{CA, 1'b1, 1'b0, 8'h5A, 1'b1, 4'd6},  // R6 still armed, fires
        '{CA, 1'b1, 1'b0, 8'hA5, 1'b0, 4'd7},  // R7 arm
        '{CA, 1'b1, 1'b0, 8'hA5, 1'b0, 4'd7},  // R7 arm again
        '{CA, 1'b1, 1'b0, 8'h5A, 1'b1, 4'd7},  // R7 fires
        '{CA, 1'b1, 1'b0, 8'hA5, 1'b0, 4'd7},  // R7 arm
        '{CA, 1'b1, 1'b0, 8'h33, 1'b0, 4'd7},  // R7 stray value disarms
        '{CA, 1'b1, 1'b0, 8'h5A, 1'b0, 4'd7},  // R7 no clear
        '{CA, 1'b1, 1'b0, 8'hA5, 1'b0, 4'd8},  // R8 arm
        '{CA, 1'b1, 1'b0, 8'h5A, 1'b1, 4'd8},  // R8 fires
        '{CA, 1'b1, 1'b0, 8'h5A, 1'b0, 4'd8},  // R8 second fire ignored
        '{OA, 1'b1, 1'b0, 8'hA5, 1'b0, 4'd6}   // R6 foreign arm attempt
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one bus cycle at a falling edge; report count before and after the next rising edge.
    task automatic bus_op(input logic [11:0] a, input logic w, input logic r,
                          input logic [7:0] d, output logic [CW-1:0] c0,
                          output logic [CW-1:0] c1, output logic [7:0] rd_val);
        @(negedge clk);
        c0 = count;
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        #1 rd_val = bus_rdata;
        @(negedge clk);
        c1 = count;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] c0, c1, pc;
        logic [7:0]    rv;
        logic [NT-1:0] pl, el, er;
        int            mis_l, mis_r, guard;

        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 count in reset", 32'(count), 0);
        chk("R1 taps in reset", 32'(tap_level), 0);
        chk("R1 pulses in reset", 32'(tap_rise), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first step after reset", 32'(count), 1);
        bus_op(CA, 1'b1, 1'b0, 8'h5A, c0, c1, rv);
        chk("R1 tracker unarmed after reset", 32'(c1), 32'(CW'(c0 + 1'b1)));

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            bus_op(VECS[i].addr, VECS[i].wr, VECS[i].rd, VECS[i].data, c0, c1, rv);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), 32'(c1),
                VECS[i].clr ? 32'd0 : 32'(CW'(c0 + 1'b1)));
            if (VECS[i].rd)
                chk("R9 read data", 32'(rv), 0);
        end
        bus_op(CA, 1'b1, 1'b0, 8'h5A, c0, c1, rv);
        chk("R6 foreign arm left tracker idle", 32'(c1), 32'(CW'(c0 + 1'b1)));

        // R3: one cycle after the clear the count reads one
        bus_op(CA, 1'b1, 1'b0, 8'hA5, c0, c1, rv);
        bus_op(CA, 1'b1, 1'b0, 8'h5A, c0, c1, rv);
        chk("R3 clear", 32'(c1), 0);
        @(negedge clk);
        chk("R3 count resumes", 32'(count), 1);

        // R1: reset drops the armed state
        bus_op(CA, 1'b1, 1'b0, 8'hA5, c0, c1, rv);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus_op(CA, 1'b1, 1'b0, 8'h5A, c0, c1, rv);
        chk("R1 reset disarms", 32'(c1), 32'(CW'(c0 + 1'b1)));

        // R4: long idle gap between keys
        bus_op(CA, 1'b1, 1'b0, 8'hA5, c0, c1, rv);
        repeat (1000) @(negedge clk);
        bus_op(CA, 1'b1, 1'b0, 8'h5A, c0, c1, rv);
        chk("R4 clear after long gap", 32'(c1), 0);

        // R9: read strobe at clear address and elsewhere
        bus_op(OA, 1'b0, 1'b1, 8'h00, c0, c1, rv);
        chk("R9 read elsewhere", 32'(rv), 0);
        bus_op(CA, 1'b0, 1'b1, 8'h00, c0, c1, rv);
        chk("R9 read clear address", 32'(rv), 0);

        // R2: wrap from all ones to zero
        guard = 0;
        @(negedge clk);
        while (count != {CW{1'b1}} && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        chk("R2 wrap to zero", 32'(count), 0);

        // R10: tap levels and pulses over a long window
        mis_l = 0; mis_r = 0;
        @(negedge clk);
        pc = count; pl = tap_level;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            for (int t = 0; t < NT; t++) el[t] = pc[TP[t]];
            er = el & ~pl;
            if (tap_level !== el) mis_l++;
            if (tap_rise !== er) mis_r++;
            pc = count; pl = tap_level;
        end
        chk("R10 tap level mismatches", 32'(mis_l), 0);
        chk("R10 tap pulse mismatches", 32'(mis_r), 0);

        // R11: clear while the top tap bit is high
        guard = 0;
        while (count < 8'd150 && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        bus_op(CA, 1'b1, 1'b0, 8'hA5, c0, c1, rv);
        @(negedge clk);
        chk("R11 top tap high before clear", 32'(tap_level[3]), 1);
        bus_op(CA, 1'b1, 1'b0, 8'h5A, c0, c1, rv);
        chk("R11 clear", 32'(c1), 0);
        @(negedge clk);
        chk("R11 taps restart", 32'(tap_level), 0);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule